// File: doc/BRIEF.md
# Strip Cluster Centroid Finder

This block takes a stream of corrected detector strips, each carrying a strip address and an unsigned amplitude. Strips arrive in ascending address order. Consecutive addresses that differ by exactly one form a run, and each run becomes one cluster. When the cluster closes, the block locates its peak strip. It then builds a window around the peak, five strips wide when the run provides two neighbours on each side and three strips wide otherwise. From that window it computes a fixed-point centroid that carries two fractional bits.

The input uses a valid/ready handshake. A cluster closes in three ways: a strip whose address is not contiguous with the run, an accepted strip flagged as the last of its event, or a run that has filled the internal buffer. While the block computes a closed cluster it holds ready low, and any strip that broke the run waits at the input. The division is iterative and takes one cycle per quotient bit. Each cluster with a non-zero window sum produces a single-cycle pulse on `out_valid`, together with the centroid and a flag that gives the window size.

Top module: `strip_centroid_finder`

## Requirements
- R1: A strip is taken only in a cycle where `in_valid` and `in_ready` are both high. From the cycle after a cluster closes until its result is emitted or discarded, `in_ready` stays low.
- R2: A strip whose address is not the previous accepted address plus one closes the current cluster. That strip is not taken in the cycle it breaks the run. It is taken later as the first strip of the next cluster.
- R3: An accepted strip with `in_last` high belongs to the current cluster and closes it immediately, so the next strip always opens a fresh cluster. Without `in_last` a lone run produces no output.
- R4: A run reaching DEPTH strips (default 8) closes at that point. The next strip starts a new cluster even when its address is contiguous.
- R5: The peak is the strip with the largest amplitude. When amplitudes are equal, the lowest address wins.
- R6: When the peak has two cluster neighbours on each side, `out_five` is 1. Writing the window amplitudes as D1..D5 in address order, `out_centroid` = 4·(peak address − 1) + trunc(4·(−D1 + D3 + 2·D4 + 3·D5) / (D1 + D2 + D3 + D4 + D5)).
- R7: In every other case `out_five` is 0. With D2, D3, D4 the amplitudes just below, at and just above the peak, and a neighbour outside the cluster counted as 0, `out_centroid` = 4·(peak address) + trunc(4·(D4 − D2) / (D2 + D3 + D4)).
- R8: The quotient truncates toward zero, so a negative offset moves the result down by the truncated magnitude.
- R9: A cluster whose window sum is zero produces no output.
- R10: Each cluster with a non-zero window sum produces exactly one result, in arrival order. `out_valid` is high for one cycle.
- R11: After reset, with `rst_n` low for at least one clock edge, `out_valid` is 0, `in_ready` is 1 and any partly collected cluster is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strip word present |
| in_ready | output | 1 | Strip word is taken this cycle when valid is high |
| in_addr | input | ADDR_W (10) | Strip address |
| in_amp | input | AMP_W (8) | Corrected strip amplitude, unsigned |
| in_last | input | 1 | Strip is the last of its event |
| out_valid | output | 1 | One-cycle result pulse |
| out_centroid | output | ADDR_W+2 (12) | Centroid address with two fractional bits |
| out_five | output | 1 | 1 for a five-strip window, 0 for three |

## Verification
The assertions assume that the upstream source obeys the handshake: a strip offered with `in_valid` stays unchanged until it is taken. They also assume addresses rise within an event and never wrap past the top of the address range. Under those conditions the contiguity check on accepted strips and the reference-address arithmetic stay meaningful. The stimulus holds each strip in place until the handshake completes and keeps every event in strictly ascending order, with all addresses well below 1023. It also places each peak so that every expected centroid is non-negative and fits in twelve bits.

// File: rtl/scf_pkg.sv
// Package: shared state encodings for the strip centroid finder.
// Assumes: nothing beyond being compiled ahead of the modules that import it.
package scf_pkg;

    typedef enum logic {
        COL_FILL = 1'b0,
        COL_HOLD = 1'b1
    } col_state_t;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_DIV  = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/scf_collect.sv
// Module: scf_collect
// Gathers a contiguous run of strips into a local buffer and tracks the peak
// (first strictly larger amplitude wins). Closes the run on an address gap,
// on an accepted last-of-event strip, or when the buffer is full, then holds
// the buffer frozen until clus_ack.
// Assumes: addresses ascend within an event and offered data is held until taken.
module scf_collect
    import scf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 8,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [ADDR_W-1:0]        in_addr,
    input  logic [AMP_W-1:0]         in_amp,
    input  logic                     in_last,
    input  logic                     clus_ack,
    output logic                     clus_hold,
    output logic [DEPTH*AMP_W-1:0]   amp_flat,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [$clog2(DEPTH)-1:0] peak_idx,
    output logic [ADDR_W-1:0]        base_addr
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    col_state_t          state_q;
    logic [AMP_W-1:0]    amp_q [DEPTH];
    logic [CNT_W-1:0]    count_q;
    logic [ADDR_W-1:0]   base_q;
    logic [ADDR_W-1:0]   last_addr_q;
    logic [IDX_W-1:0]    peak_idx_q;
    logic [AMP_W-1:0]    peak_amp_q;
    logic                gap;
    logic                accept;
    logic                full_next;

    // Detect an offered strip that does not continue the open run.
    always_comb begin
        gap = in_valid && (count_q != '0) && (in_addr != last_addr_q + ADDR_W'(1));
    end

    assign in_ready  = (state_q == COL_FILL) && !gap;
    assign accept    = in_valid && in_ready;
    assign full_next = (count_q == CNT_W'(DEPTH-1));
    assign clus_hold = (state_q == COL_HOLD);
    assign count     = count_q;
    assign peak_idx  = peak_idx_q;
    assign base_addr = base_q;

    // Flatten the buffer for the window selector.
    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_flat
            assign amp_flat[gi*AMP_W +: AMP_W] = amp_q[gi];
        end
    endgenerate

    // Store accepted strips, track the peak and sequence fill/hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= COL_FILL;
            count_q     <= '0;
            base_q      <= '0;
            last_addr_q <= '0;
            peak_idx_q  <= '0;
            peak_amp_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                amp_q[i] <= '0;
            end
        end else if (state_q == COL_FILL) begin
            if (accept) begin
                amp_q[count_q[IDX_W-1:0]] <= in_amp;
                last_addr_q <= in_addr;
                count_q     <= count_q + CNT_W'(1);
                if (count_q == '0) begin
                    base_q <= in_addr;
                end
                if ((count_q == '0) || (in_amp > peak_amp_q)) begin
                    peak_idx_q <= count_q[IDX_W-1:0];
                    peak_amp_q <= in_amp;
                end
                if (in_last || full_next) begin
                    state_q <= COL_HOLD;
                end
            end else if (gap) begin
                state_q <= COL_HOLD;
            end
        end else if (clus_ack) begin
            state_q <= COL_FILL;
            count_q <= '0;
        end
    end

    // R2: every strip joining an open run is contiguous with it.
    p_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && count_q != '0) |-> (in_addr == last_addr_q + ADDR_W'(1)));

    // R3: a taken last-of-event strip stalls the input on the next cycle.
    p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> !in_ready);

    // R4: filling the final buffer slot closes the run.
    p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && full_next) |=> clus_hold);

    // R1: a held cluster keeps its contents until released.
    p_hold_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clus_hold && !clus_ack) |=> ($stable(count_q) && $stable(peak_idx_q) && clus_hold));

endmodule

// File: rtl/scf_window.sv
// Module: scf_window
// Combinational window former: picks five strips around the peak when two
// neighbours exist on each side inside the cluster, else three strips with a
// missing neighbour read as zero. Produces the signed weighted numerator, the
// amplitude sum and the window reference address (second strip of the window).
// Assumes: count >= 1 and peak_idx < count whenever the outputs are used.
module scf_window #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 8,
    parameter int DEPTH  = 8
) (
    input  logic [DEPTH*AMP_W-1:0]     amp_flat,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [$clog2(DEPTH)-1:0]   peak_idx,
    input  logic [ADDR_W-1:0]          base_addr,
    output logic                       five,
    output logic signed [AMP_W+3:0]    num,
    output logic [AMP_W+2:0]           den,
    output logic [ADDR_W-1:0]          ref_addr
);

    localparam int NUM_W = AMP_W + 4;
    localparam int DEN_W = AMP_W + 3;

    logic [AMP_W-1:0] d1, d2, d3, d4, d5;

    // Zero-extend an amplitude into the signed numerator width.
    function automatic logic signed [NUM_W-1:0] ext(input logic [AMP_W-1:0] v);
        return signed'({{(NUM_W-AMP_W){1'b0}}, v});
    endfunction

    // Gather the up-to-five amplitudes around the peak inside the run.
    always_comb begin
        int p;
        int n;
        p  = int'(peak_idx);
        n  = int'(count);
        d1 = '0;
        d2 = '0;
        d3 = '0;
        d4 = '0;
        d5 = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < n) begin
                if (i == p - 2) d1 = amp_flat[i*AMP_W +: AMP_W];
                if (i == p - 1) d2 = amp_flat[i*AMP_W +: AMP_W];
                if (i == p)     d3 = amp_flat[i*AMP_W +: AMP_W];
                if (i == p + 1) d4 = amp_flat[i*AMP_W +: AMP_W];
                if (i == p + 2) d5 = amp_flat[i*AMP_W +: AMP_W];
            end
        end
        five = (p >= 2) && (p + 2 < n);
    end

    // Weighted numerator, denominator and reference for the chosen width.
    always_comb begin
        if (five) begin
            num = ext(d3) - ext(d1) + (ext(d4) <<< 1) + (ext(d5) <<< 1) + ext(d5);
            den = DEN_W'(d1) + DEN_W'(d2) + DEN_W'(d3) + DEN_W'(d4) + DEN_W'(d5);
        end else begin
            num = ext(d4) - ext(d2);
            den = DEN_W'(d2) + DEN_W'(d3) + DEN_W'(d4);
        end
        ref_addr = base_addr + ADDR_W'(peak_idx) - ADDR_W'(five);
    end

endmodule

// File: rtl/scf_divider.sv
// Module: scf_divider
// Restoring unsigned divider, one quotient bit per cycle, MAG_W cycles per
// division. done pulses for one cycle with the quotient valid alongside it.
// Assumes: divisor is non-zero whenever start is raised; start only when idle.
module scf_divider #(
    parameter int MAG_W = 13,
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MAG_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [MAG_W-1:0] quotient
);

    localparam int CNT_W = $clog2(MAG_W + 1);

    logic [MAG_W-1:0] dq_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             take;

    // Trial subtraction for the current quotient bit.
    always_comb begin
        shifted = {rem_q, dq_q[MAG_W-1]};
        diff    = shifted - {1'b0, den_q};
        take    = (shifted >= {1'b0, den_q});
    end

    // Load operands on start, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q   <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            dq_q   <= dividend;
            rem_q  <= '0;
            den_q  <= divisor;
            cnt_q  <= CNT_W'(MAG_W);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            rem_q <= take ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
            dq_q  <= {dq_q[MAG_W-2:0], take};
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign quotient = dq_q;

    // R9: a division is never launched with a zero divisor.
    p_nonzero_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (divisor != '0));

    // R8: the partial remainder stays below the divisor throughout.
    p_rem_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < den_q));

endmodule

// File: rtl/strip_centroid_finder.sv
// Module: strip_centroid_finder (top)
// Chains the run collector, the window former and the iterative divider.
// A closed cluster with zero window sum is released at once without output;
// otherwise the scaled magnitude of the numerator is divided, the sign is
// reapplied (truncating toward zero) and a one-cycle result is emitted.
// Assumes: addresses ascend without wrap, so the centroid is non-negative.
module strip_centroid_finder
    import scf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [AMP_W-1:0]  in_amp,
    input  logic              in_last,
    output logic              out_valid,
    output logic [ADDR_W+1:0] out_centroid,
    output logic              out_five
);

    localparam int NUM_W  = AMP_W + 4;
    localparam int DEN_W  = AMP_W + 3;
    localparam int MAG_W  = NUM_W + 1;
    localparam int CENT_W = ADDR_W + 2;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH+1);

    logic                    clus_hold;
    logic                    clus_ack;
    logic [DEPTH*AMP_W-1:0]  amp_flat;
    logic [CNT_W-1:0]        count;
    logic [IDX_W-1:0]        peak_idx;
    logic [ADDR_W-1:0]       base_addr;
    logic                    win_five;
    logic signed [NUM_W-1:0] win_num;
    logic [DEN_W-1:0]        win_den;
    logic [ADDR_W-1:0]       win_ref;
    logic [NUM_W-1:0]        num_mag;
    logic [MAG_W-1:0]        dividend;
    logic                    div_start;
    logic                    div_busy;
    logic                    div_done;
    logic [MAG_W-1:0]        quotient;
    logic [CENT_W-1:0]       q_short;
    logic [CENT_W-1:0]       ref_scaled;

    ctl_state_t              ctl_q;
    logic [ADDR_W-1:0]       ref_q;
    logic                    neg_q;
    logic                    five_q;
    logic                    out_valid_q;
    logic [CENT_W-1:0]       out_cent_q;
    logic                    out_five_q;

    scf_collect #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W),
        .DEPTH  (DEPTH)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_addr   (in_addr),
        .in_amp    (in_amp),
        .in_last   (in_last),
        .clus_ack  (clus_ack),
        .clus_hold (clus_hold),
        .amp_flat  (amp_flat),
        .count     (count),
        .peak_idx  (peak_idx),
        .base_addr (base_addr)
    );

    scf_window #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W),
        .DEPTH  (DEPTH)
    ) u_window (
        .amp_flat  (amp_flat),
        .count     (count),
        .peak_idx  (peak_idx),
        .base_addr (base_addr),
        .five      (win_five),
        .num       (win_num),
        .den       (win_den),
        .ref_addr  (win_ref)
    );

    // Magnitude of the numerator scaled by four for the two fraction bits.
    always_comb begin
        num_mag  = win_num[NUM_W-1] ? NUM_W'(-win_num) : NUM_W'(win_num);
        dividend = {num_mag[NUM_W-2:0], 2'b00};
    end

    scf_divider #(
        .MAG_W (MAG_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (dividend),
        .divisor  (win_den),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (quotient)
    );

    // Launch a division or release a zero-sum cluster.
    always_comb begin
        div_start = (ctl_q == CTL_IDLE) && clus_hold && (win_den != '0);
        clus_ack  = ((ctl_q == CTL_IDLE) && clus_hold && (win_den == '0))
                  || ((ctl_q == CTL_DIV) && div_done);
        q_short    = CENT_W'(quotient);
        ref_scaled = {ref_q, 2'b00};
    end

    // Sequence each cluster and register the signed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= CTL_IDLE;
            ref_q       <= '0;
            neg_q       <= 1'b0;
            five_q      <= 1'b0;
            out_valid_q <= 1'b0;
            out_cent_q  <= '0;
            out_five_q  <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            if (ctl_q == CTL_IDLE) begin
                if (div_start) begin
                    ref_q  <= win_ref;
                    neg_q  <= win_num[NUM_W-1];
                    five_q <= win_five;
                    ctl_q  <= CTL_DIV;
                end
            end else if (div_done) begin
                out_valid_q <= 1'b1;
                out_cent_q  <= neg_q ? (ref_scaled - q_short) : (ref_scaled + q_short);
                out_five_q  <= five_q;
                ctl_q       <= CTL_IDLE;
            end
        end
    end

    assign out_valid    = out_valid_q;
    assign out_centroid = out_cent_q;
    assign out_five     = out_five_q;

    // R10: a result is a single-cycle pulse.
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R1: a result only follows a cycle in which the input was stalled.
    p_stall_before_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(!in_ready));

    // R9: releasing a zero-sum cluster never yields a result next cycle.
    p_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clus_hold && !div_busy && !div_done && win_den == '0) |=> !out_valid);

endmodule

// File: tb/test_strip_centroid_finder.sv
module test_strip_centroid_finder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [9:0]  in_addr = '0;
    logic [7:0]  in_amp = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [11:0] out_centroid;
    logic        out_five;

    int checks = 0;
    int failures = 0;
    int stalls = 0;
    int got_n = 0;
    int pulse_run = 0;
    logic [11:0] got_cent [64];
    logic        got_five [64];

    always #2 clk = ~clk;

    strip_centroid_finder i_strip_centroid_finder (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_addr      (in_addr),
        .in_amp       (in_amp),
        .in_last      (in_last),
        .out_valid    (out_valid),
        .out_centroid (out_centroid),
        .out_five     (out_five)
    );

    // Stimulus strips: {addr, amp, last}.
    localparam int NSTIM = 37;
    localparam logic [18:0] STIM [NSTIM] = '{
        {10'd10, 8'd10, 1'b0}, {10'd11, 8'd20, 1'b0}, {10'd12, 8'd60, 1'b0},
        {10'd13, 8'd30, 1'b0}, {10'd14, 8'd10, 1'b0},
        {10'd20, 8'd5, 1'b0}, {10'd21, 8'd50, 1'b0}, {10'd22, 8'd25, 1'b0},
        {10'd30, 8'd40, 1'b1},
        {10'd40, 8'd60, 1'b0}, {10'd41, 8'd90, 1'b0}, {10'd42, 8'd10, 1'b0},
        {10'd50, 8'd5, 1'b0}, {10'd51, 8'd10, 1'b0}, {10'd52, 8'd70, 1'b0},
        {10'd53, 8'd20, 1'b0}, {10'd54, 8'd70, 1'b0}, {10'd55, 8'd10, 1'b0},
        {10'd56, 8'd5, 1'b1},
        {10'd100, 8'd1, 1'b0}, {10'd101, 8'd2, 1'b0}, {10'd102, 8'd3, 1'b0},
        {10'd103, 8'd4, 1'b0}, {10'd104, 8'd5, 1'b0}, {10'd105, 8'd6, 1'b0},
        {10'd106, 8'd7, 1'b0}, {10'd107, 8'd8, 1'b0}, {10'd108, 8'd9, 1'b0},
        {10'd109, 8'd9, 1'b1},
        {10'd200, 8'd0, 1'b0}, {10'd201, 8'd0, 1'b1},
        {10'd210, 8'd100, 1'b1},
        {10'd700, 8'd1, 1'b0}, {10'd701, 8'd1, 1'b0}, {10'd702, 8'd255, 1'b0},
        {10'd703, 8'd255, 1'b0}, {10'd704, 8'd255, 1'b1}
    };

    // Expected results: {centroid, five}, in cluster order.
    localparam int NEXP = 9;
    localparam logic [12:0] EXPV [NEXP] = '{
        {12'd48,   1'b1},
        {12'd85,   1'b0},
        {12'd120,  1'b0},
        {12'd163,  1'b0},
        {12'd211,  1'b1},
        {12'd427,  1'b0},
        {12'd434,  1'b0},
        {12'd840,  1'b0},
        {12'd2811, 1'b1}
    };
    // R6 five-strip, R2 gap break, R7 lone strip, R8 negative truncation,
    // R5 tie to lowest, R4 cap split (two), R9 zero-sum skipped, R6 large.
    string exp_req [NEXP] = '{"R6", "R2", "R7", "R8", "R5", "R4", "R4", "R9", "R6"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [9:0] a, input logic [7:0] m, input logic l);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        in_amp   = m;
        in_last  = l;
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // Record every result pulse and its width.
    always @(negedge clk) begin
        if (out_valid) begin
            if (got_n < 64) begin
                got_cent[got_n] = out_centroid;
                got_five[got_n] = out_five;
            end
            got_n++;
            pulse_run++;
            if (pulse_run > 1) check(1'b0, "R10 pulse width", pulse_run, 1);
        end else begin
            pulse_run = 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=timeout expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        // Reset state (R11).
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);

        // Table walk.
        for (int i = 0; i < NSTIM; i++) begin
            send(STIM[i][18:9], STIM[i][8:1], STIM[i][0]);
        end
        idle();
        repeat (100) @(negedge clk);
        check(got_n == NEXP, "R10 result count", got_n, NEXP);
        for (int k = 0; k < NEXP; k++) begin
            check(got_cent[k] == EXPV[k][12:1], exp_req[k], int'(got_cent[k]), int'(EXPV[k][12:1]));
            check(got_five[k] == EXPV[k][0], {exp_req[k], " five flag"}, int'(got_five[k]), int'(EXPV[k][0]));
        end
        check(stalls > 0, "R1 input stalled during close", stalls, 1);

        // R3: a run without the last flag stays pending; the flag flushes it.
        base = got_n;
        send(10'd900, 8'd9, 1'b0);
        idle();
        repeat (60) @(negedge clk);
        check(got_n == base, "R3 no output before flush", got_n - base, 0);
        send(10'd901, 8'd9, 1'b1);
        idle();
        repeat (60) @(negedge clk);
        check(got_n == base + 1, "R3 flush count", got_n - base, 1);
        check(got_cent[base] == 12'd3602, "R3 flush centroid", int'(got_cent[base]), 3602);

        // R11: reset mid-cluster discards the partial run.
        base = got_n;
        send(10'd950, 8'd50, 1'b0);
        idle();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        #1;
        check(got_n == base, "R11 partial run dropped", got_n - base, 0);
        check(in_ready == 1'b1, "R11 ready after mid reset", int'(in_ready), 1);
        send(10'd951, 8'd4, 1'b1);
        idle();
        repeat (60) @(negedge clk);
        check(got_n == base + 1, "R11 fresh cluster count", got_n - base, 1);
        check(got_cent[base] == 12'd3804, "R11 fresh cluster centroid", int'(got_cent[base]), 3804);
        check(got_five[base] == 1'b0, "R7 fresh cluster three-strip", int'(got_five[base]), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule